// File: doc/BRIEF.md
# Selectable Ratio Clock Divider

This block derives a slow system clock from a fast source clock by dividing it by 2, 4 or 8. A second output carries the fast clock divided by 3 with a one-third high duty. Both outputs start from a known, repeatable phase of the fast clock. That phase is fixed by the moment the divider is let go after reset, not by when reset happens to fall.

The divider starts in two steps. An active-high reset clears all divider state and pulls both outputs low at once. Once reset has dropped, the outputs stay low until a release strobe is seen on a rising fast-clock edge. That edge becomes phase zero: both outputs go high on it and then count from it. Several dividers in a system can therefore be started together by one shared release strobe.

The ratio is captured only while reset is held. A change to the select during operation has no effect until the next reset and release.

Top module: `clkdiv_sel`

## Requirements
- R1: The ratio select is decoded as 2'b00 = divide by 2, 2'b01 = divide by 4, 2'b10 = divide by 8, and 2'b11 = divide by 8.
- R2: While `rst` is high, `clk_div_o` and `clk_div3_o` are low and all divider state is cleared, asynchronously to the fast clock.
- R3: After `rst` falls, both outputs stay low until `release_i` is sampled high on a rising edge of `clk_fast`.
- R4: `clk_div_o` goes high on the rising edge that samples the release. It then changes level every N/2 fast edges, giving a 50% duty at ratio N.
- R5: Once running, further pulses on `release_i`, or a release held high, do not disturb the output phase until the next reset.
- R6: `ratio_sel` is captured on rising edges while `rst` is high. Changing it while the divider runs has no effect on the output.
- R7: `clk_div3_o` goes high on the same release edge. It is high for one fast period and low for two, repeating every 3 fast edges.
- R8: A reset applied while running drops both outputs immediately. A later release restarts the outputs at phase zero with the ratio captured during that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock |
| rst | input | 1 | Active-high asynchronous reset; ratio is captured while high |
| ratio_sel | input | 2 | Division ratio select (R1 encoding) |
| release_i | input | 1 | Start strobe, sampled on rising edges of clk_fast |
| clk_div_o | output | 1 | Clock divided by 2, 4 or 8 |
| clk_div3_o | output | 1 | Clock divided by 3, one-third duty |

## Verification
The bench counts fast edges from the release edge and compares every sampled level of both outputs against a phase computed independently from the ratio. This catches a divider that starts one edge late, that starts low, or that uses the wrong half period. Release pulses and ratio changes are injected in mid-run; a design that rearmed on release or followed the live select would show a phase jump. A reset is dropped in and checked without waiting for a clock edge, so a synchronous-only clear shows up as a high output. The outputs are also held in the waiting state for several cycles, so a divider that free-runs from reset is caught.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Ratio select encoding; code 3 aliases divide by 8
  typedef enum logic [1:0] {
    DIV_BY2     = 2'b00,
    DIV_BY4     = 2'b01,
    DIV_BY8     = 2'b10,
    DIV_BY8_ALT = 2'b11
  } ratio_e;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } phase_e;

  // Number of fast edges per output level (R1)
  function automatic logic [3:0] half_period(input logic [1:0] sel);
    case (ratio_e'(sel))
      DIV_BY2: half_period = 4'd1;
      DIV_BY4: half_period = 4'd2;
      default: half_period = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       release_i,
  input  logic [1:0] sel_i,
  output logic [1:0] ratio_o,
  output logic       start_o,
  output logic       run_o
);

  phase_e st;

  // Ratio captured only while reset is held (R6)
  always_ff @(posedge clk) begin
    if (rst) ratio_o <= sel_i;
  end

  assign start_o = (st == ST_WAIT) && release_i;
  assign run_o   = (st == ST_RUN);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          st <= ST_WAIT;
    else if (start_o) st <= ST_RUN;
  end

  // R5
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    run_o |=> run_o);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_o && !release_i) |=> !run_o);

endmodule

// File: rtl/clkdiv_even.sv
`timescale 1ns/1ps
module clkdiv_even #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             div_o
);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == half_i - CNT_W'(1));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      div_o <= 1'b0;
      cnt   <= '0;
    end else if (start_i) begin
      div_o <= 1'b1;
      cnt   <= '0;
    end else if (run_i) begin
      if (wrap) begin
        div_o <= ~div_o;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R4
  rise_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> div_o);

  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> !div_o);

endmodule

// File: rtl/clkdiv_div3.sv
`timescale 1ns/1ps
module clkdiv_div3 (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic div3_o
);

  logic [1:0] cnt3;
  logic       last;

  assign last = (cnt3 == 2'd2);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      div3_o <= 1'b0;
      cnt3   <= 2'd0;
    end else if (start_i) begin
      div3_o <= 1'b1;
      cnt3   <= 2'd0;
    end else if (run_i) begin
      div3_o <= last;
      cnt3   <= last ? 2'd0 : cnt3 + 2'd1;
    end
  end

  // R7
  div3_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div3_o) |=> !div3_o);

  // R7
  div3_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> div3_o);

endmodule

// File: rtl/clkdiv_sel.sv
`timescale 1ns/1ps
module clkdiv_sel
  import clkdiv_pkg::*;
#(
  parameter int MAX_RATIO = 8
) (
  input  logic       clk_fast,
  input  logic       rst,
  input  logic [1:0] ratio_sel,
  input  logic       release_i,
  output logic       clk_div_o,
  output logic       clk_div3_o
);

  localparam int CNT_W = $clog2(MAX_RATIO / 2) + 1;

  logic [1:0]       ratio_q;
  logic             start_evt;
  logic             running;
  logic [CNT_W-1:0] half_cnt;

  assign half_cnt = CNT_W'(half_period(ratio_q));

  clkdiv_ctrl u_ctrl (
    .clk       (clk_fast),
    .rst       (rst),
    .release_i (release_i),
    .sel_i     (ratio_sel),
    .ratio_o   (ratio_q),
    .start_o   (start_evt),
    .run_o     (running)
  );

  clkdiv_even #(.CNT_W(CNT_W)) u_even (
    .clk     (clk_fast),
    .rst     (rst),
    .start_i (start_evt),
    .run_i   (running),
    .half_i  (half_cnt),
    .div_o   (clk_div_o)
  );

  clkdiv_div3 u_div3 (
    .clk     (clk_fast),
    .rst     (rst),
    .start_i (start_evt),
    .run_i   (running),
    .div3_o  (clk_div3_o)
  );

  // R3
  div3_idle_chk: assert property (@(posedge clk_fast) disable iff (rst)
    !running |-> (!clk_div3_o && !clk_div_o));

endmodule

// File: tb/tb_clkdiv_sel.sv
`timescale 1ns/1ps
module tb_clkdiv_sel;

  logic       clk_fast = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ratio_sel = 2'b00;
  logic       release_i = 1'b0;
  logic       clk_div_o, clk_div3_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk_fast = ~clk_fast;

  clkdiv_sel dut (
    .clk_fast   (clk_fast),
    .rst        (rst),
    .ratio_sel  (ratio_sel),
    .release_i  (release_i),
    .clk_div_o  (clk_div_o),
    .clk_div3_o (clk_div3_o)
  );

  function automatic int exp_half(input logic [1:0] s);
    return 1 << ((s > 2'd2) ? 2 : int'(s));
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0b expected %0b", req, $time, act, exp);
    end
  endtask

  // R2 and R3: reset with ratio capture, then idle before release
  task automatic do_reset(input logic [1:0] s, input int idle);
    @(negedge clk_fast);
    rst = 1'b1;
    ratio_sel = s;
    #1;
    check("R2 div low in reset", clk_div_o, 1'b0);
    check("R2 div3 low in reset", clk_div3_o, 1'b0);
    repeat (3) @(negedge clk_fast);
    rst = 1'b0;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk_fast);
      check("R3 div low before release", clk_div_o, 1'b0);
      check("R3 div3 low before release", clk_div3_o, 1'b0);
    end
  endtask

  // R4, R7 (and R5, R6 via poke): release then check phase per edge
  task automatic run_check(input logic [1:0] s, input int nsamp,
                           input int poke_at, input bit hold_rel);
    int h;
    h = exp_half(s);
    @(negedge clk_fast);
    release_i = 1'b1;
    @(negedge clk_fast);
    if (!hold_rel) release_i = 1'b0;
    for (int k = 0; k < nsamp; k++) begin
      check("R4/R1 divided phase", clk_div_o, ((k / h) % 2) == 0);
      check("R7 div3 phase", clk_div3_o, (k % 3) == 0);
      if (k == poke_at) begin
        release_i = 1'b1;      // R5: ignored
        ratio_sel = ~ratio_sel; // R6: ignored
      end else if (k == poke_at + 1) begin
        release_i = hold_rel;
      end
      @(negedge clk_fast);
    end
    release_i = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    check("R2 div low at start", clk_div_o, 1'b0);
    check("R2 div3 low at start", clk_div3_o, 1'b0);
    // R1 R4 R7: each encoding
    do_reset(2'b00, 4); run_check(2'b00, 24, -5, 1'b0);
    do_reset(2'b01, 6); run_check(2'b01, 24, -5, 1'b0);
    do_reset(2'b10, 3); run_check(2'b10, 32, -5, 1'b0);
    do_reset(2'b11, 2); run_check(2'b11, 32, -5, 1'b0);
    // R5 R6: mid-run release pulse and ratio change
    do_reset(2'b01, 2); run_check(2'b01, 30, 9, 1'b0);
    do_reset(2'b10, 2); run_check(2'b10, 30, 5, 1'b0);
    // R5: release held high throughout
    do_reset(2'b00, 2); run_check(2'b00, 20, -5, 1'b1);
    // R8: reset in mid-run, asynchronous drop, restart with new ratio
    do_reset(2'b10, 1);
    @(negedge clk_fast);
    release_i = 1'b1;
    @(negedge clk_fast);
    release_i = 1'b0;
    #1;
    rst = 1'b1;
    #0.5;
    check("R8 div dropped by reset", clk_div_o, 1'b0);
    check("R8 div3 dropped by reset", clk_div3_o, 1'b0);
    do_reset(2'b01, 3); run_check(2'b01, 20, -5, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule